// File: doc/BRIEF.md
# Configurable Timer with Capture

A 32-bit timer peripheral reached through a plain register bus. Software programs a reload value and a control word. The control word picks:

- one of several clock-enable strobes, followed by a power-of-two prescaler;
- the count direction;
- periodic or free-running behaviour;
- plain binary counting or a time-of-day layout of hours, minutes, seconds and hundredths.

Each time the count reaches its terminal value, the block produces a timeout. An 8-bit postscaler counts these timeouts. The interrupt can follow every timeout, or only the timeouts on which the postscaler matches its programmed value.

A capture unit watches one of 17 event strobes. When the selected event fires, it copies the running count into a read-only capture register.

All clock sources arrive as single-cycle enable strobes in the system clock domain, so the whole block runs on one clock. A write of any value to the clear address drops the interrupt and the compare flag, and restarts the count from the reload value. Register word addresses are:

| Address | Register | Access |
|---|---|---|
| 0 | reload | read/write |
| 1 | count | read only |
| 2 | capture | read only |
| 3 | control | read/write |
| 4 | clear | write only |

Unmapped reads return zero.

Top module: `cfg_timer`

## Requirements
- R1: After reset, the reload, count, capture and control registers all read zero, and `irq` is low.
- R2: The reload register (address 0) reads back what was written to it. A write to it also places the written value into the count, which is readable at address 1, on the next cycle.
- R3: The timer counts only while control bit 7 is 1. Control bit 8 set to 0 selects counting down, and 1 selects counting up. With bit 7 at 0, the count holds whatever strobes arrive.
- R4: Control bits 11:9 select the strobe that clocks the timer: code k selects `src_tick[k]`, and other strobes are ignored. Control bits 3:0 hold a code p, and the count advances once every 2^p selected strobes.
- R5: The terminal value is 0 when counting down, and all ones (or the time-of-day maximum) when counting up. On a step from the terminal value the timer produces a timeout. With control bit 6 at 1 (periodic), it then loads the reload value. With bit 6 at 0 (free-running), it wraps to the opposite end of its range.
- R6: When control bits 5:4 are 10 or 11, the count holds hundredths in bits 7:0, seconds in bits 15:8, minutes in bits 23:16 and hours in bits 31:24. Hundredths roll over at 99, and seconds and minutes at 59, each with a carry or borrow into the next field. The hour limit is 23 for code 10 and 255 for code 11. Codes 00 and 01 count in binary.
- R7: When control bit 17 is 1, a strobe on `evt_in[s]` copies the count into the capture register (address 2). Here s is the value in control bits 16:12, from 0 to 16. Strobes on other events, and all strobes while bit 17 is 0, leave the capture register unchanged.
- R8: Control bits 31:24 (the postscaler value) change only on a control write that has bit 23 set. Bit 23 reads back as 0.
- R9: The postscaler counts timeouts and matches on timeout number N+1, where N is the postscaler value. A match sets the compare flag, which reads as control bit 19. With control bit 18 at 0, every timeout raises `irq`. With bit 18 at 1, only a match raises it. `irq` stays high until cleared.
- R10: A write to the clear address (4) drops `irq` and the compare flag, restarts the postscaler, and reloads the count from the reload register on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| src_tick | input | 4 | Clock-source enable strobes |
| evt_in | input | 17 | Event strobes for capture |
| irq | output | 1 | Timer interrupt, held high until cleared |

## Verification
The hardest state to reach is a postscaler match that gates the interrupt. It requires several complete terminal-to-reload cycles, with the flag and `irq` staying low until exactly timeout N+1. The stimulus makes this quick by loading a reload value of 1 in periodic down mode, so each timeout costs only two strobes. The time-of-day rollovers are reached the same way: the bench loads values one step away from each carry, borrow and wrap boundary, and then gives a single strobe.

// File: rtl/cfg_timer_pkg.sv
package cfg_timer_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAPT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR = 3'd4;

  typedef struct packed {
    logic [7:0] post;
    logic       irq_on_post;
    logic       cap_en;
    logic [4:0] evt_sel;
    logic [2:0] src_sel;
    logic       up;
    logic       en;
    logic       periodic;
    logic [1:0] fmt;
    logic [3:0] psc;
  } ctrl_t;

  function automatic logic [DW-1:0] tod_max(input logic wide);
    tod_max = {(wide ? 8'd255 : 8'd23), 8'd59, 8'd59, 8'd99};
  endfunction

  function automatic logic [DW-1:0] tod_inc(input logic [DW-1:0] v);
    logic [7:0] h, m, s, c;
    {h, m, s, c} = v;
    if (c < 8'd99) c = c + 8'd1;
    else begin
      c = 8'd0;
      if (s < 8'd59) s = s + 8'd1;
      else begin
        s = 8'd0;
        if (m < 8'd59) m = m + 8'd1;
        else begin
          m = 8'd0;
          h = h + 8'd1;
        end
      end
    end
    tod_inc = {h, m, s, c};
  endfunction

  function automatic logic [DW-1:0] tod_dec(input logic [DW-1:0] v);
    logic [7:0] h, m, s, c;
    {h, m, s, c} = v;
    if (c != 8'd0) c = c - 8'd1;
    else begin
      c = 8'd99;
      if (s != 8'd0) s = s - 8'd1;
      else begin
        s = 8'd59;
        if (m != 8'd0) m = m - 8'd1;
        else begin
          m = 8'd59;
          h = h - 8'd1;
        end
      end
    end
    tod_dec = {h, m, s, c};
  endfunction
endpackage

// File: rtl/cfg_timer_regs.sv
module cfg_timer_regs
  import cfg_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              flag,
  input  logic [DW-1:0]     cnt,
  input  logic [DW-1:0]     cap,
  output logic [DW-1:0]     rd_data,
  output ctrl_t             ctrl,
  output logic [DW-1:0]     reload,
  output logic              load,
  output logic [DW-1:0]     load_val,
  output logic              clear,
  output logic              restart
);
  ctrl_t         ctrl_d;
  logic [DW-1:0] reload_d;
  logic          wr_load, wr_ctrl;

  always_comb begin
    wr_load  = wr_en && (wr_addr == A_LOAD);
    wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    clear    = wr_en && (wr_addr == A_CLEAR);
    restart  = wr_ctrl || clear;
    load     = wr_load || clear;
    load_val = wr_load ? wr_data : reload;

    reload_d = wr_load ? wr_data : reload;
    ctrl_d   = ctrl;
    if (wr_ctrl) begin
      ctrl_d.psc         = wr_data[3:0];
      ctrl_d.fmt         = wr_data[5:4];
      ctrl_d.periodic    = wr_data[6];
      ctrl_d.en          = wr_data[7];
      ctrl_d.up          = wr_data[8];
      ctrl_d.src_sel     = wr_data[11:9];
      ctrl_d.evt_sel     = wr_data[16:12];
      ctrl_d.cap_en      = wr_data[17];
      ctrl_d.irq_on_post = wr_data[18];
      if (wr_data[23]) ctrl_d.post = wr_data[31:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else begin
      ctrl   <= ctrl_d;
      reload <= reload_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_LOAD:  rd_data = reload;
      A_COUNT: rd_data = cnt;
      A_CAPT:  rd_data = cap;
      A_CTRL:  rd_data = {ctrl.post, 4'b0000, flag, ctrl.irq_on_post,
                          ctrl.cap_en, ctrl.evt_sel, ctrl.src_sel, ctrl.up,
                          ctrl.en, ctrl.periodic, ctrl.fmt, ctrl.psc};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cfg_timer_tick.sv
module cfg_timer_tick #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_tick,
  input  logic [2:0]       src_sel,
  input  logic [PSC_W-1:0] psc,
  input  logic             en,
  input  logic             restart,
  output logic             cnt_tick
);
  localparam int unsigned PRE_W = (1 << PSC_W) - 1;

  logic [N_SRC-1:0] hit;
  logic             src_hit;
  logic [PRE_W-1:0] pre_cnt, pre_cnt_d, mask;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = src_tick[g] && (src_sel == 3'(g));
  end

  always_comb begin
    src_hit   = |hit;
    mask      = ~({PRE_W{1'b1}} << psc);
    cnt_tick  = en && src_hit && ((pre_cnt & mask) == mask);
    pre_cnt_d = pre_cnt;
    if (restart)             pre_cnt_d = '0;
    else if (en && src_hit)  pre_cnt_d = pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt_d;
  end
endmodule

// File: rtl/cfg_timer_core.sv
module cfg_timer_core
  import cfg_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          up,
  input  logic          periodic,
  input  logic [1:0]    fmt,
  input  logic [DW-1:0] reload,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt,
  output logic          timeout
);
  logic [DW-1:0] cnt_d, top_val, step, wrap;
  logic          at_term, tod;

  always_comb begin
    tod     = fmt[1];
    top_val = tod ? tod_max(fmt[0]) : {DW{1'b1}};
    at_term = up ? (cnt == top_val) : (cnt == '0);
    if (tod) step = up ? tod_inc(cnt) : tod_dec(cnt);
    else     step = up ? cnt + 1'b1 : cnt - 1'b1;
    wrap    = up ? '0 : top_val;
    timeout = cnt_tick && at_term && !load;

    cnt_d = cnt;
    if (load)          cnt_d = load_val;
    else if (cnt_tick) cnt_d = at_term ? (periodic ? reload : wrap) : step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/cfg_timer_post.sv
module cfg_timer_post
  import cfg_timer_pkg::*;
#(
  parameter int unsigned N_EVT = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timeout,
  input  logic [7:0]       post_val,
  input  logic             irq_on_post,
  input  logic             clear,
  input  logic             cap_en,
  input  logic [4:0]       evt_sel,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [DW-1:0]    cnt,
  output logic             flag,
  output logic             irq,
  output logic [DW-1:0]    cap
);
  logic [7:0]       post_cnt, post_cnt_d;
  logic             match, flag_d, irq_d;
  logic [N_EVT-1:0] ev_hit;
  logic [DW-1:0]    cap_d;

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    assign ev_hit[g] = evt_in[g] && (evt_sel == 5'(g));
  end

  always_comb begin
    match      = timeout && (post_cnt == post_val);
    post_cnt_d = post_cnt;
    flag_d     = flag;
    irq_d      = irq;
    if (clear) begin
      post_cnt_d = '0;
      flag_d     = 1'b0;
      irq_d      = 1'b0;
    end else if (timeout) begin
      post_cnt_d = match ? 8'd0 : post_cnt + 8'd1;
      if (match) flag_d = 1'b1;
      if (match || !irq_on_post) irq_d = 1'b1;
    end
    cap_d = (cap_en && |ev_hit) ? cnt : cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cnt <= '0;
      flag     <= 1'b0;
      irq      <= 1'b0;
      cap      <= '0;
    end else begin
      post_cnt <= post_cnt_d;
      flag     <= flag_d;
      irq      <= irq_d;
      cap      <= cap_d;
    end
  end
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
  import cfg_timer_pkg::*;
#(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned N_EVT = 17,
  parameter int unsigned PSC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [N_SRC-1:0]  src_tick,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              irq
);
  logic [1:0]    rst_q;
  logic          rst_sync_n;
  ctrl_t         ctrl;
  logic [DW-1:0] reload, load_val, cnt, cap;
  logic          load, clear, restart, cnt_tick, timeout, flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  cfg_timer_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .flag(flag), .cnt(cnt), .cap(cap),
    .rd_data(rd_data), .ctrl(ctrl), .reload(reload), .load(load),
    .load_val(load_val), .clear(clear), .restart(restart)
  );

  cfg_timer_tick #(.N_SRC(N_SRC), .PSC_W(PSC_W)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .src_tick(src_tick),
    .src_sel(ctrl.src_sel), .psc(ctrl.psc[PSC_W-1:0]), .en(ctrl.en),
    .restart(restart), .cnt_tick(cnt_tick)
  );

  cfg_timer_core u_core (
    .clk(clk), .rst_n(rst_sync_n), .cnt_tick(cnt_tick), .up(ctrl.up),
    .periodic(ctrl.periodic), .fmt(ctrl.fmt), .reload(reload), .load(load),
    .load_val(load_val), .cnt(cnt), .timeout(timeout)
  );

  cfg_timer_post #(.N_EVT(N_EVT)) u_post (
    .clk(clk), .rst_n(rst_sync_n), .timeout(timeout), .post_val(ctrl.post),
    .irq_on_post(ctrl.irq_on_post), .clear(clear), .cap_en(ctrl.cap_en),
    .evt_sel(ctrl.evt_sel), .evt_in(evt_in), .cnt(cnt), .flag(flag),
    .irq(irq), .cap(cap)
  );
endmodule

// File: rtl/cfg_timer_chk.sv
module cfg_timer_chk
  import cfg_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              irq,
  input logic              tmr_en,
  input logic              cap_en,
  input logic [7:0]        post_val,
  input logic [DW-1:0]     cnt,
  input logic [DW-1:0]     cap,
  input logic              timeout
);
  AST_LOAD_TO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_LOAD) |=> (cnt == $past(wr_data))); // R2

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !wr_en) |=> $stable(cnt)); // R3

  AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap)); // R7

  AST_POST_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && !wr_data[23]) |=> $stable(post_val)); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(timeout)); // R9

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLEAR) |=> !irq); // R10
endmodule

bind cfg_timer cfg_timer_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .tmr_en(ctrl.en), .cap_en(ctrl.cap_en),
  .post_val(ctrl.post), .cnt(cnt), .cap(cap), .timeout(timeout)
);

// File: tb/cfg_timer_bench.sv
module cfg_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wr_en, irq;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [3:0]  src_tick;
  logic [16:0] evt_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    bit          is_irq;
    logic [2:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  cfg_timer u_cfg_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_tick(src_tick), .evt_in(evt_in), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items and compares against the design
  initial begin
    rd_addr = 3'd0;
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        rd_addr = it.addr;
        #1;
        act = it.is_irq ? {31'd0, irq} : rd_data;
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string t);
    item_t it;
    it.is_irq = 0; it.addr = a; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic expect_irq(input logic e, input string t);
    item_t it;
    it.is_irq = 1; it.addr = 3'd0; it.exp = {31'd0, e}; it.tag = t;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n, input int idx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_tick[idx] = 1'b1;
      @(negedge clk);
      src_tick = '0;
    end
  endtask

  task automatic pulse_evt(input int idx);
    @(negedge clk);
    evt_in[idx] = 1'b1;
    @(negedge clk);
    evt_in = '0;
  endtask

  localparam logic [2:0] LD = 3'd0, CN = 3'd1, CP = 3'd2, CT = 3'd3, CL = 3'd4;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    src_tick = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_reg(LD, 32'h0, "R1 reload");
    expect_reg(CN, 32'h0, "R1 count");
    expect_reg(CP, 32'h0, "R1 capture");
    expect_reg(CT, 32'h0, "R1 control");
    expect_irq(1'b0, "R1 irq");

    // R2 reload write and copy into count
    wr(LD, 32'd5);
    expect_reg(LD, 32'd5, "R2 reload readback");
    expect_reg(CN, 32'd5, "R2 count loaded");

    // R3 down count, source 1
    wr(CT, 32'h0000_0280);
    tick(3, 1);
    expect_reg(CN, 32'd2, "R3 down count");
    tick(2, 0);
    expect_reg(CN, 32'd2, "R4 other source ignored");
    wr(CT, 32'h0000_0200);
    tick(2, 1);
    expect_reg(CN, 32'd2, "R3 disabled holds");

    // R4 prescaler divide by 16
    wr(CT, 32'h0000_0284);
    tick(15, 1);
    expect_reg(CN, 32'd2, "R4 prescale not yet");
    tick(1, 1);
    expect_reg(CN, 32'd1, "R4 prescale step");

    // R5 free-running down wrap, R9 irq on every timeout
    wr(CT, 32'h0000_0280);
    tick(1, 1);
    expect_reg(CN, 32'd0, "R5 reach zero");
    expect_irq(1'b0, "R9 no irq before timeout");
    tick(1, 1);
    expect_reg(CN, 32'hFFFF_FFFF, "R5 free wrap down");
    expect_irq(1'b1, "R9 irq on timeout");
    expect_reg(CT, 32'h0008_0280, "R9 flag set");
    wr(CL, 32'h0);
    expect_irq(1'b0, "R10 irq cleared");
    expect_reg(CN, 32'd5, "R10 count reloaded");
    expect_reg(CT, 32'h0000_0280, "R10 flag cleared");

    // R5 periodic up
    wr(LD, 32'hFFFF_FFFE);
    wr(CT, 32'h0000_03C0);
    tick(1, 1);
    expect_reg(CN, 32'hFFFF_FFFF, "R5 up to terminal");
    tick(1, 1);
    expect_reg(CN, 32'hFFFF_FFFE, "R5 periodic up reload");
    expect_irq(1'b1, "R5 periodic up timeout");
    wr(CL, 32'h0);

    // R5 periodic down
    wr(LD, 32'd2);
    wr(CT, 32'h0000_02C0);
    tick(2, 1);
    expect_reg(CN, 32'd0, "R5 down to zero");
    expect_irq(1'b0, "R5 no early timeout");
    tick(1, 1);
    expect_reg(CN, 32'd2, "R5 periodic down reload");
    expect_irq(1'b1, "R5 periodic down timeout");
    wr(CL, 32'h0);

    // R6 time of day up, 23-hour limit
    wr(CT, 32'h0000_03A0);
    wr(LD, 32'h0102_3B63);
    tick(1, 1);
    expect_reg(CN, 32'h0103_0000, "R6 carry chain");
    wr(LD, 32'h173B_3B62);
    tick(1, 1);
    expect_reg(CN, 32'h173B_3B63, "R6 at max");
    tick(1, 1);
    expect_reg(CN, 32'h0000_0000, "R6 wrap at 23h");
    expect_irq(1'b1, "R6 timeout at max");
    wr(CL, 32'h0);

    // R6 time of day down, 255-hour limit
    wr(CT, 32'h0000_02B0);
    wr(LD, 32'h0500_0000);
    tick(1, 1);
    expect_reg(CN, 32'h043B_3B63, "R6 borrow chain");
    wr(LD, 32'h0);
    tick(1, 1);
    expect_reg(CN, 32'hFF3B_3B63, "R6 down wrap 255h");
    wr(CL, 32'h0);

    // R8 postscaler write guard
    wr(CT, 32'h5500_02C0);
    expect_reg(CT, 32'h0000_02C0, "R8 post unchanged");

    // R9 postscaler match gates irq (post value 2 -> third timeout)
    wr(LD, 32'd1);
    wr(CT, 32'h0284_02C0);
    wr(CL, 32'h0);
    expect_reg(CT, 32'h0204_02C0, "R8 post written");
    tick(4, 1);
    expect_irq(1'b0, "R9 no irq after two timeouts");
    expect_reg(CT, 32'h0204_02C0, "R9 no flag yet");
    tick(2, 1);
    expect_irq(1'b1, "R9 irq on match");
    expect_reg(CT, 32'h020C_02C0, "R9 flag on match");
    wr(CL, 32'h0);

    // R7 capture
    wr(CT, 32'h0002_5000);
    wr(LD, 32'h0000_1234);
    pulse_evt(3);
    expect_reg(CP, 32'h0, "R7 unselected event ignored");
    pulse_evt(5);
    expect_reg(CP, 32'h0000_1234, "R7 capture selected");
    wr(CT, 32'h0000_5000);
    wr(LD, 32'h0000_0099);
    pulse_evt(5);
    expect_reg(CP, 32'h0000_1234, "R7 capture disabled");
    wr(CT, 32'h0003_0000);
    pulse_evt(16);
    expect_reg(CP, 32'h0000_0099, "R7 event 16");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule